// File: doc/BRIEF.md
# Page-Mode Parallel ROM Reader

This block is a synchronous controller that reads an asynchronous parallel mask ROM. The ROM holds 2M sixteen-bit words, or 4M bytes when it is switched to byte width. A host sends a byte address and a width select over a valid/ready request channel. The block drives the ROM address bus, a shared chip-enable/output-enable pair and the width select. It holds that address steady for as many clock cycles as the ROM needs. It then samples the data bus and returns the result with a one-cycle valid pulse.

A page holds sixteen bytes, which is eight words. Addresses with equal bits 4 and up, read at the same width, fall in the same page. The controller remembers which page is open. A read that misses the open page waits the long random-access time. A read that hits the open page waits only the short in-page time. In word mode address bit 0 is ignored. In byte mode bit 0 chooses the byte, and the byte comes back on the low eight data lines.

When the bus has had no request for a set number of cycles, the controller releases the ROM by deasserting its enables. It then lets the ROM's outputs float before anything may use the bus again. Every wait time is given in clock cycles on configuration inputs. A value of zero selects a built-in default. The defaults suit the slowest speed grade at a 4 ns clock.

Top module: `pmrom_reader`

## Requirements
- R1: During and after reset, with no request, `rom_ce_n`, `rom_oe_n` and `rom_byte_n` are 1, `rsp_valid` is 0, and `req_ready` and `bus_free` are 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after that edge until the response cycle. It is 1 again in the response cycle. `rsp_valid` is a single-cycle pulse, so at most one read is outstanding.
- R3: A read that misses the open page, or that arrives with no page open, has its response cycle begin N edges after the accepting edge. N is the larger of the random-access count and the output-enable count.
- R4: A read that hits the open page has its response cycle begin N edges after the accepting edge, where N is the in-page count.
- R5: In word mode (`req_byte`=0), `rom_byte_n` is 1 and `rom_addr` bit 0 is driven 0. `rsp_data` is the full 16-bit ROM word, so an odd address returns the same word as the even address below it.
- R6: In byte mode (`req_byte`=1), `rom_byte_n` is 0 and all 22 address bits are passed on. `rsp_data` is {8'h00, `rom_dq[7:0]`}, and a page covers 16 consecutive byte addresses.
- R7: From the accepting edge until the sampling edge, `rom_addr` is stable and `rom_ce_n` and `rom_oe_n` are 0. The address changes only when a new request is accepted.
- R8: If I cycles pass after a response with no request accepted, the enables are deasserted and the page is closed, so the next read takes the R3 wait. A request waiting on the edge where the close would happen is taken instead, and the page stays open.
- R9: After a close, for F cycles `rom_ce_n` and `rom_oe_n` stay 1 while `req_ready` and `bus_free` are 0. `bus_free` is 1 only when both enables are deasserted and no float window is running.
- R10: Each count input (random, page, output-enable, float, idle) is used as given when nonzero. A zero selects the default: 30, 7, 7, 5 and 16 cycles.
- R11: A read whose width select differs from the open page's width is a miss, even if the address bits match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 22 | Byte address of the read |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| cfg_rand_cyc | input | 8 | Random-access wait in cycles (0 = default) |
| cfg_page_cyc | input | 8 | In-page wait in cycles (0 = default) |
| cfg_oe_cyc | input | 8 | Minimum output-enable lead in cycles (0 = default) |
| cfg_float_cyc | input | 8 | Bus float hold-off in cycles (0 = default) |
| cfg_idle_cyc | input | 8 | Idle cycles before release (0 = default) |
| rsp_valid | output | 1 | One-cycle pulse marking returned data |
| rsp_data | output | 16 | Read data, zero-extended in byte mode |
| rom_addr | output | 22 | ROM address lines |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select, 0 = byte |
| rom_dq | input | 16 | ROM data lines |
| bus_free | output | 1 | ROM released and its outputs have floated |

## Verification
Each read's response is due exactly N edges after its accepting edge. N comes from R3 or R4. The bench works out N from its own record of the open page, width and idle gap, then counts falling edges from acceptance to the first `rsp_valid`. It compares that count with N, so an early or late response fails.

The behavioural ROM returns inverted data whenever it is sampled before its random, in-page or output-enable age has elapsed. A premature sample therefore shows up as a data mismatch. The float window is measured by counting the cycles between a release and the return of `bus_free`. That count must equal F. Idle gaps of I-1 and I cycles test both sides of the close boundary.

// File: rtl/pmrom_pkg.sv
package pmrom_pkg;

  // Controller phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FLOAT = 2'd2
  } rd_state_e;

  // Slot index of each timing count in the packed configuration vector
  localparam int unsigned K_RAND  = 0;
  localparam int unsigned K_PAGE  = 1;
  localparam int unsigned K_OE    = 2;
  localparam int unsigned K_FLOAT = 3;
  localparam int unsigned K_IDLE  = 4;
  localparam int unsigned K_NUM   = 5;

endpackage

// File: rtl/pmrom_cfg_sel.sv
// Resolves each timing count: a zero field falls back to its default,
// and a result is never below one cycle.
module pmrom_cfg_sel #(
  parameter int unsigned       CW   = 8,
  parameter int unsigned       NV   = 5,
  parameter logic [NV*CW-1:0]  DEFS = '0
) (
  input  logic [NV*CW-1:0] raw_i,
  output logic [NV*CW-1:0] eff_o
);

  for (genvar i = 0; i < NV; i++) begin : g_fld
    localparam logic [CW-1:0] DEF_I   = DEFS[i*CW +: CW];
    localparam logic [CW-1:0] FALLBCK = (DEF_I != '0) ? DEF_I : CW'(1);
    logic [CW-1:0] fld;
    assign fld                = raw_i[i*CW +: CW];
    assign eff_o[i*CW +: CW]  = (fld != '0) ? fld : FALLBCK;
  end

endmodule

// File: rtl/pmrom_page_trk.sv
// Remembers which page (upper address bits plus width) is open on the ROM.
module pmrom_page_trk #(
  parameter int unsigned KW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_i,
  input  logic          close_i,
  input  logic [KW-1:0] key_i,
  input  logic          mode_i,
  output logic          hit_o
);

  logic          vld_q;
  logic [KW-1:0] key_q;
  logic          mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      key_q  <= '0;
      mode_q <= 1'b0;
    end else if (open_i) begin
      vld_q  <= 1'b1;
      key_q  <= key_i;
      mode_q <= mode_i;
    end else if (close_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign hit_o = vld_q && (key_q == key_i) && (mode_q == mode_i);

endmodule

// File: rtl/pmrom_wait_ctr.sv
// Loadable down counter; last_o marks the final cycle of a loaded interval.
module pmrom_wait_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/pmrom_reader.sv
module pmrom_reader
  import pmrom_pkg::*;
#(
  parameter int unsigned AW        = 22,
  parameter int unsigned DW        = 16,
  parameter int unsigned CW        = 8,
  parameter int unsigned PB        = 4,
  parameter int unsigned DEF_RAND  = 30,
  parameter int unsigned DEF_PAGE  = 7,
  parameter int unsigned DEF_OE    = 7,
  parameter int unsigned DEF_FLOAT = 5,
  parameter int unsigned DEF_IDLE  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_byte,
  input  logic [CW-1:0] cfg_rand_cyc,
  input  logic [CW-1:0] cfg_page_cyc,
  input  logic [CW-1:0] cfg_oe_cyc,
  input  logic [CW-1:0] cfg_float_cyc,
  input  logic [CW-1:0] cfg_idle_cyc,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] rom_addr,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  output logic          rom_byte_n,
  input  logic [DW-1:0] rom_dq,
  output logic          bus_free
);

  localparam int unsigned BW = DW / 2;
  localparam int unsigned KW = AW - PB;
  localparam logic [K_NUM*CW-1:0] DEFS = {CW'(DEF_IDLE), CW'(DEF_FLOAT),
                                          CW'(DEF_OE), CW'(DEF_PAGE),
                                          CW'(DEF_RAND)};

  // Timing counts after default substitution
  logic [K_NUM*CW-1:0] cfg_raw, cfg_eff;
  logic [CW-1:0]       t_rand, t_page, t_oe, t_float, t_idle, t_miss;

  assign cfg_raw = {cfg_idle_cyc, cfg_float_cyc, cfg_oe_cyc,
                    cfg_page_cyc, cfg_rand_cyc};

  pmrom_cfg_sel #(.CW(CW), .NV(K_NUM), .DEFS(DEFS)) u_cfg (
    .raw_i (cfg_raw),
    .eff_o (cfg_eff)
  );

  assign t_rand  = cfg_eff[K_RAND*CW  +: CW];
  assign t_page  = cfg_eff[K_PAGE*CW  +: CW];
  assign t_oe    = cfg_eff[K_OE*CW    +: CW];
  assign t_float = cfg_eff[K_FLOAT*CW +: CW];
  assign t_idle  = cfg_eff[K_IDLE*CW  +: CW];
  // A fresh access needs both the address time and the output-enable lead
  assign t_miss  = (t_rand > t_oe) ? t_rand : t_oe;

  // State
  rd_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic          byte_q;
  logic          en_q;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;

  logic          acc, page_hit, idle_close, wait_done, tmr_last, tmr_load;
  logic [CW-1:0] tmr_val;
  logic [AW-1:0] acc_addr;

  assign acc        = req_valid && (state_q == ST_IDLE);
  assign wait_done  = (state_q == ST_WAIT) && tmr_last;
  assign idle_close = (state_q == ST_IDLE) && en_q && tmr_last && !req_valid;

  // Word reads drive address bit 0 low; byte reads keep it
  assign acc_addr = {req_addr[AW-1:1], req_byte & req_addr[0]};

  pmrom_page_trk #(.KW(KW)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_i  (acc),
    .close_i (idle_close),
    .key_i   (req_addr[AW-1:PB]),
    .mode_i  (req_byte),
    .hit_o   (page_hit)
  );

  // One timer serves the access wait, the idle countdown and the float window
  always_comb begin
    tmr_load = acc || wait_done || idle_close;
    if (acc)             tmr_val = (page_hit && en_q) ? t_page : t_miss;
    else if (wait_done)  tmr_val = t_idle;
    else                 tmr_val = t_float;
  end

  pmrom_wait_ctr #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .last_o (tmr_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      byte_q      <= 1'b0;
      en_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (acc) begin
            addr_q  <= acc_addr;
            byte_q  <= req_byte;
            en_q    <= 1'b1;
            state_q <= ST_WAIT;
          end else if (idle_close) begin
            en_q    <= 1'b0;
            state_q <= ST_FLOAT;
          end
        end
        ST_WAIT: begin
          if (tmr_last) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= byte_q ? {{(DW-BW){1'b0}}, rom_dq[BW-1:0]} : rom_dq;
            state_q     <= ST_IDLE;
          end
        end
        ST_FLOAT: begin
          if (tmr_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_data   = rsp_data_q;
  assign rom_addr   = addr_q;
  assign rom_ce_n   = ~en_q;
  assign rom_oe_n   = ~en_q;
  assign rom_byte_n = ~byte_q;
  assign bus_free   = !en_q && (state_q == ST_IDLE);

endmodule

// File: rtl/pmrom_reader_chk.sv
module pmrom_reader_chk #(
  parameter int unsigned AW        = 22,
  parameter int unsigned DW        = 16,
  parameter int unsigned CW        = 8,
  parameter int unsigned DEF_FLOAT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic [AW-1:0] rom_addr,
  input logic          rom_ce_n,
  input logic          rom_oe_n,
  input logic          rom_byte_n,
  input logic          bus_free,
  input logic [CW-1:0] cfg_float_cyc
);

  localparam int unsigned BW = DW / 2;

  logic [CW-1:0] flt_need;
  logic [CW:0]   flt_cnt;

  assign flt_need = (cfg_float_cyc != '0) ? cfg_float_cyc : CW'(DEF_FLOAT);

  // Cycles spent released but not yet free
  always_ff @(posedge clk) begin
    if (!rst_n)                       flt_cnt <= '0;
    else if (rom_ce_n && !bus_free)   flt_cnt <= flt_cnt + 1'b1;
    else                              flt_cnt <= '0;
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_word_a0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && rom_byte_n) |-> !rom_addr[0]);

  p_byte_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rom_byte_n) |-> (rsp_data[DW-1:BW] == '0));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !rom_ce_n) |=> $stable(rom_addr) && !rom_oe_n);

  p_float_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_ce_n && !bus_free) |-> (rom_oe_n && !req_ready));

  p_float_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> (flt_cnt == {1'b0, flt_need}));

endmodule

bind pmrom_reader pmrom_reader_chk #(
  .AW(AW), .DW(DW), .CW(CW), .DEF_FLOAT(DEF_FLOAT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_data      (rsp_data),
  .rom_addr      (rom_addr),
  .rom_ce_n      (rom_ce_n),
  .rom_oe_n      (rom_oe_n),
  .rom_byte_n    (rom_byte_n),
  .bus_free      (bus_free),
  .cfg_float_cyc (cfg_float_cyc)
);

// File: tb/pmrom_reader_tb.sv
`timescale 1ns/1ps
module pmrom_reader_tb;

  localparam int AW = 22;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_byte;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] cfg_rand_cyc, cfg_page_cyc, cfg_oe_cyc, cfg_float_cyc, cfg_idle_cyc;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] rom_addr;
  logic          rom_ce_n, rom_oe_n, rom_byte_n, bus_free;
  logic [DW-1:0] rom_dq;

  always #2 clk = ~clk;

  pmrom_reader u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte),
    .cfg_rand_cyc(cfg_rand_cyc), .cfg_page_cyc(cfg_page_cyc),
    .cfg_oe_cyc(cfg_oe_cyc), .cfg_float_cyc(cfg_float_cyc),
    .cfg_idle_cyc(cfg_idle_cyc), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_byte_n(rom_byte_n), .rom_dq(rom_dq), .bus_free(bus_free)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  // Effective timing the bench expects
  int tr = 30, tp = 7, to = 7, tf = 5, ti = 16;
  // Bench view of the open page
  bit open_ok = 1'b0;
  logic [AW-5:0] o_key;
  bit o_mode;

  // ROM content as a function of the word address
  function automatic logic [15:0] word_val(input logic [AW-2:0] wa);
    logic [31:0] t;
    t = {11'd0, wa} * 32'h9E3779B1;
    return t[31:16] ^ t[15:0];
  endfunction

  function automatic logic [15:0] exp_data(input logic [AW-1:0] a, input bit bm);
    logic [15:0] w;
    w = word_val(a[AW-1:1]);
    if (!bm) return w;
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  // Behavioural ROM: ages counted at falling edges, early samples corrupted
  logic [AW-1:0] m_addr = '0;
  logic m_bn = 1'b1, m_ce_n = 1'b1, m_oe_n = 1'b1;
  int age_any = 0, age_up = 0, age_oe = 0;

  always @(negedge clk) begin
    if (rom_ce_n || m_ce_n) begin
      age_any = 0; age_up = 0;
    end else begin
      if (rom_addr != m_addr) age_any = 0; else if (age_any < 1000) age_any++;
      if (rom_addr[AW-1:4] != m_addr[AW-1:4] || rom_byte_n != m_bn) age_up = 0;
      else if (age_up < 1000) age_up++;
    end
    if (rom_oe_n || m_oe_n) age_oe = 0; else if (age_oe < 1000) age_oe++;
    m_addr = rom_addr; m_bn = rom_byte_n; m_ce_n = rom_ce_n; m_oe_n = rom_oe_n;
  end

  always_comb begin
    logic [15:0] w, raw;
    bit ok;
    w   = word_val(rom_addr[AW-1:1]);
    raw = rom_byte_n ? w : {8'hFF, rom_addr[0] ? w[15:8] : w[7:0]};
    ok  = !rom_ce_n && !rom_oe_n && (age_any + 1 >= tp) &&
          (age_up + 1 >= tr) && (age_oe + 1 >= to);
    rom_dq = ok ? raw : ~raw;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // One read; gap = extra idle falling edges before the request is raised
  task automatic do_read(input logic [AW-1:0] a, input bit bm, input int gap,
                         input string rq);
    int lat, exp_lat;
    bit hit;
    logic [AW-1:0] exp_a;
    repeat (gap) @(negedge clk);
    hit = open_ok && (gap < ti) && (o_mode == bm) && (o_key == a[AW-1:4]);
    exp_lat = hit ? tp : ((tr > to) ? tr : to);
    exp_a = {a[AW-1:1], bm & a[0]};
    req_valid = 1'b1; req_addr = a; req_byte = bm;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    chk(!req_ready, "R2", "ready after accept", int'(req_ready), 0);
    chk(rom_addr == exp_a, bm ? "R6" : "R5", "rom_addr", int'(rom_addr), int'(exp_a));
    chk(!rom_ce_n && !rom_oe_n && (rom_byte_n == !bm), "R7", "enables/width",
        int'({rom_ce_n, rom_oe_n, rom_byte_n}), int'({2'b00, !bm}));
    while (!rsp_valid && lat < 600) begin
      @(negedge clk);
      lat++;
    end
    chk(lat - 1 == exp_lat, hit ? "R4" : "R3", "latency", lat - 1, exp_lat);
    chk(rsp_data == exp_data(a, bm), bm ? "R6" : "R5", "data",
        int'(rsp_data), int'(exp_data(a, bm)));
    chk(req_ready && rom_addr == exp_a, "R7", "ready/addr at response",
        int'(rom_addr), int'(exp_a));
    open_ok = 1'b1; o_key = a[AW-1:4]; o_mode = bm;
  endtask

  // Long idle after a read: count the float window and confirm release
  task automatic idle_gap(input int n);
    int fl;
    fl = 0;
    repeat (n) begin
      @(negedge clk);
      if (rom_ce_n && !bus_free) fl++;
    end
    chk(fl == tf, "R9", "float cycles", fl, tf);
    chk(rom_ce_n && rom_oe_n && bus_free && req_ready, "R8", "released",
        int'({rom_ce_n, rom_oe_n, bus_free, req_ready}), 15);
    open_ok = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_byte = 1'b0;
    cfg_rand_cyc = '0; cfg_page_cyc = '0; cfg_oe_cyc = '0;
    cfg_float_cyc = '0; cfg_idle_cyc = '0;
    repeat (4) @(negedge clk);
    chk(rom_ce_n && rom_oe_n && rom_byte_n, "R1", "enables in reset",
        int'({rom_ce_n, rom_oe_n, rom_byte_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready && bus_free, "R1", "idle outputs",
        int'({rsp_valid, req_ready, bus_free}), 3);
    chk(rom_ce_n && rom_oe_n, "R1", "enables after reset",
        int'({rom_ce_n, rom_oe_n}), 3);

    // Defaults (R10): miss 30, hit 7, float 5, idle 16
    do_read(22'h012345, 1'b0, 0, "R10");   // R3 first read, R5 odd word
    do_read(22'h01234A, 1'b0, 0, "R4");    // same page
    do_read(22'h01235A, 1'b0, 1, "R3");    // upper bits changed
    do_read(22'h01235B, 1'b1, 0, "R11");   // width change forces a miss
    do_read(22'h01235C, 1'b1, 2, "R6");    // byte page hit, low byte
    do_read(22'h01235F, 1'b1, 0, "R6");    // byte page hit, high byte
    idle_gap(40);                           // R8 close, R9 float
    do_read(22'h01235E, 1'b1, 0, "R8");    // miss after close
    do_read(22'h012350, 1'b1, ti - 1, "R8"); // one short of close: hit
    do_read(22'h012351, 1'b1, ti, "R8");     // exactly the close: miss
    do_read(22'h3ABCD1, 1'b0, 0, "R5");
    idle_gap(40);

    // Programmed counts (R10): output-enable lead dominates the miss wait
    cfg_rand_cyc = 8'd12; cfg_page_cyc = 8'd3; cfg_oe_cyc = 8'd15;
    cfg_float_cyc = 8'd2; cfg_idle_cyc = 8'd4;
    tr = 12; tp = 3; to = 15; tf = 2; ti = 4;
    begin
      bit bm;
      bm = 1'b0;
      for (int i = 0; i < 300; i++) begin
        logic [AW-1:0] a;
        int g;
        if ($urandom_range(0, 7) == 0) bm = !bm;
        a = {14'h3FF0, 8'($urandom_range(0, 255))};
        g = $urandom_range(0, 6);
        do_read(a, bm, g, "R10");
      end
    end
    idle_gap(20);

    done = 1'b1;
    finish_run();
  end

endmodule